// File: doc/BRIEF.md
# Posted Store Buffer with Writer Stall

The block sits between a cache and main memory and absorbs stores so that the processor does not wait for the memory. Each accepted store is an address/data pair. It is placed in a small first-in first-out queue in the same cycle it is offered. The memory side takes the oldest entry whenever the memory signals that it can accept it. Draining runs alongside new stores and stops only when the queue is empty.

When every slot is occupied and nothing leaves in the current cycle, a stall output holds the writer. The block never forwards data out of the queue. A read whose address matches a store that is still queued raises a hold output. That output stays high until every matching entry has reached memory, so a read cannot see stale data.

Top module: `post_wbuf`

## Requirements
- R1: While reset is applied, and in the first cycles after it, the queue is empty. `buf_empty` is 1, and `buf_full`, `mem_valid` and `wr_stall` are 0.
- R2: `mem_addr` and `mem_data` always show the oldest queued store. Stores reach memory in the exact order they were accepted.
- R3: A store offered with `wr_req` is accepted at the rising edge whenever `wr_stall` is low, one store per cycle. A store accepted into an empty queue makes `mem_valid` high in the following cycle.
- R4: `buf_full` is 1 when DEPTH stores are queued. `wr_stall` is 1 exactly when the queue is full and no entry retires in that cycle.
- R5: An entry retires only at an edge where `mem_valid` and `mem_ready` are both 1. With `mem_ready` low, the head address and data stay unchanged.
- R6: If a store is accepted in the same cycle an entry retires, the occupancy does not change. A full queue stays full and takes the new store.
- R7: `rd_hold` is 1 exactly when `rd_req` is 1 and `rd_addr` equals the address of at least one queued entry. It falls once all matching entries have retired.
- R8: `mem_valid` is 1 whenever at least one store is queued. `buf_empty` is 1 exactly when none is.
- R9: A store offered while `wr_stall` is 1 is dropped. It is never queued and never reaches the memory side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_req | input | 1 | Store offered by the processor |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Hold the processor; the offered store is not taken |
| rd_req | input | 1 | Read lookup valid |
| rd_addr | input | AW | Read address to check against queued stores |
| rd_hold | output | 1 | Read must wait: its address is still queued |
| mem_valid | output | 1 | Head entry presented to memory |
| mem_addr | output | AW | Head entry address |
| mem_data | output | DW | Head entry data |
| mem_ready | input | 1 | Memory accepts the head entry |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |

## Verification
`wr_stall`, `rd_hold`, `mem_valid`, `mem_addr`, `mem_data`, `buf_full` and `buf_empty` depend on the stored state and the current inputs through logic only. They are therefore due in the same cycle the inputs are driven. Any change of stored state from an accepted store or a retirement shows at these outputs one edge later. Reset release passes through a two-flop synchronizer, so the bench waits several cycles after release before it starts. The bench drives its inputs just after the falling edge and samples the outputs one time unit later. It then advances its reference queue at the rising edge, using the accept and retire decisions it computed for that same cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned WB_DEPTH_DEF = 8;
  parameter int unsigned WB_AW_DEF    = 32;
  parameter int unsigned WB_DW_DEF    = 32;

  function automatic int unsigned wb_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = WB_DEPTH_DEF,
  parameter int unsigned AW    = WB_AW_DEF,
  parameter int unsigned DW    = WB_DW_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [DEPTH-1:0][AW-1:0] slot_addr,
  output logic [DEPTH-1:0]         slot_vld,
  output logic                     full,
  output logic                     empty
);
  localparam int unsigned PTR_W = wb_idx_w(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    vld_d    = vld_q;
    cnt_d    = cnt_q + CNT_W'(push) - CNT_W'(pop);
    if (pop) begin
      rd_ptr_d        = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      vld_d[rd_ptr_q] = 1'b0;
    end
    if (push) begin
      wr_ptr_d        = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      vld_d[wr_ptr_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      vld_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      vld_q    <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign slot_addr = addr_q;
  assign slot_vld  = vld_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q));
  assert_vld_matches_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (vld_q == '0));
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = WB_DEPTH_DEF,
  parameter int unsigned AW    = WB_AW_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req,
  input  logic [AW-1:0]            rd_addr,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [DEPTH-1:0]         slot_vld,
  output logic                     hold
);
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = slot_vld[g] && (slot_addr[g] == rd_addr);
  end

  assign hold = rd_req && (|hit);

  assert_hold_needs_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (rd_req && (slot_vld != '0)));
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = WB_DEPTH_DEF,
  parameter int unsigned AW    = WB_AW_DEF,
  parameter int unsigned DW    = WB_DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stall,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hold,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ready,
  output logic          buf_full,
  output logic          buf_empty
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic push, pop, full, empty;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0]         slot_vld;

  assign pop      = !empty && mem_ready;
  assign wr_stall = full && !pop;
  assign push     = wr_req && !wr_stall;

  wbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .slot_addr (slot_addr),
    .slot_vld  (slot_vld),
    .full      (full),
    .empty     (empty)
  );

  wbuf_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .slot_addr (slot_addr),
    .slot_vld  (slot_vld),
    .hold      (rd_hold)
  );

  assign mem_valid = !empty;
  assign buf_full  = full;
  assign buf_empty = empty;

  assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  assert_stall_when_full_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (buf_full && !mem_ready) |-> wr_stall);
  assert_excl_flags_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(buf_full && buf_empty));
  assert_fill_shows_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (buf_empty && wr_req) |=> mem_valid);
endmodule

// File: tb/test_post_wbuf.sv
module test_post_wbuf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_req, rd_req, mem_ready;
  logic [AW-1:0] wr_addr, rd_addr, mem_addr;
  logic [DW-1:0] wr_data, mem_data;
  logic wr_stall, rd_hold, mem_valid, buf_full, buf_empty;

  int checks = 0;
  int failures = 0;
  logic [AW+DW-1:0] mq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  post_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_post_wbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_hold(rd_hold),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .buf_full(buf_full), .buf_empty(buf_empty)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    foreach (mq[i]) if (mq[i][AW+DW-1:DW] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit model_retire(input bit rdy);
    return (mq.size() != 0) && rdy;
  endfunction

  function automatic bit model_stall(input bit rdy);
    return (mq.size() == DEPTH) && !model_retire(rdy);
  endfunction

  // One cycle: drive after the falling edge, check, then update the model at the rising edge.
  task automatic step(input bit w, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input bit r, input logic [AW-1:0] ra, input bit rdy);
    bit exp_stall, exp_ret;
    @(negedge clk);
    wr_req = w; wr_addr = wa; wr_data = wd;
    rd_req = r; rd_addr = ra; mem_ready = rdy;
    #1;
    exp_ret   = model_retire(rdy);
    exp_stall = model_stall(rdy);
    check(buf_empty == (mq.size() == 0), "R8 empty", 64'(buf_empty), 64'(mq.size() == 0));
    check(mem_valid == (mq.size() != 0), "R3 R8 valid", 64'(mem_valid), 64'(mq.size() != 0));
    check(buf_full == (mq.size() == DEPTH), "R4 full", 64'(buf_full), 64'(mq.size() == DEPTH));
    check(wr_stall == exp_stall, "R4 R6 stall", 64'(wr_stall), 64'(exp_stall));
    check(rd_hold == (r && model_hit(ra)), "R7 hold", 64'(rd_hold), 64'(r && model_hit(ra)));
    if (mq.size() != 0)
      check({mem_addr, mem_data} == mq[0], "R2 R5 R9 head", {mem_addr, mem_data}, mq[0]);
    @(posedge clk);
    if (exp_ret) void'(mq.pop_front());
    if (w && !exp_stall) mq.push_back({wa, wd});
  endtask

  function automatic logic [AW-1:0] pick_addr();
    return AW'({$urandom_range(0, 15), 2'b00});
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] held_a;
    logic [DW-1:0] held_d;
    void'($urandom(32'h1234_5eed));
    rst_n = 1'b0; wr_req = 0; rd_req = 0; mem_ready = 0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(buf_empty == 1'b1, "R1 empty", 64'(buf_empty), 64'd1);
    check(buf_full == 1'b0, "R1 full", 64'(buf_full), 64'd0);
    check(mem_valid == 1'b0, "R1 valid", 64'(mem_valid), 64'd0);
    check(wr_stall == 1'b0, "R1 stall", 64'(wr_stall), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R3: store into empty queue appears the next cycle
    step(1, 32'h100, 32'hA000_0001, 0, 0, 0);
    step(0, 0, 0, 1, 32'h100, 0);
    check(mem_valid == 1'b1, "R3 valid after one store", 64'(mem_valid), 64'd1);
    // fill to full with memory not ready
    for (int i = 1; i < DEPTH; i++) step(1, 32'h100 + 32'(4*i), 32'hA000_0000 + 32'(i+1), 0, 0, 0);
    held_a = mem_addr; held_d = mem_data;
    // R9: stalled store dropped
    step(1, 32'h0DEAD, 32'hDEAD_DEAD, 1, 32'h0DEAD, 0);
    // R5: head unchanged while not ready
    check(mem_addr == held_a && mem_data == held_d, "R5 head held", {mem_addr, mem_data}, {held_a, held_d});
    // R6: full, retire and accept together
    step(1, 32'h200, 32'hB000_0001, 0, 0, 1);
    check(buf_full == 1'b1, "R6 still full", 64'(buf_full), 64'd1);
    // R7: hold on a pending address, drain until empty (R8)
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 32'h200, 1);
    check(buf_empty == 1'b1, "R8 drained", 64'(buf_empty), 64'd1);
    check(rd_hold == 1'b0, "R7 hold released", 64'(rd_hold), 64'd0);

    // random phases with different write and ready rates
    for (int ph = 0; ph < 4; ph++) begin
      int wp, rp;
      wp = (ph == 0) ? 80 : (ph == 1) ? 95 : (ph == 2) ? 30 : 60;
      rp = (ph == 0) ? 30 : (ph == 1) ? 10 : (ph == 2) ? 90 : 50;
      for (int c = 0; c < 600; c++)
        step($urandom_range(0, 99) < wp, pick_addr(), $urandom(),
             $urandom_range(0, 1), pick_addr(), $urandom_range(0, 99) < rp);
    end
    for (int c = 0; c < DEPTH + 4; c++) step(0, 0, 0, 0, 0, 1);
    check(buf_empty == 1'b1, "R8 final drain", 64'(buf_empty), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule